// File: doc/BRIEF.md
# Warp Memory Coalescing Unit

This block sits between a group of execution lanes and a memory port that moves whole aligned lines. On a start request it captures one byte address and one active bit per lane, reduces every active address to the aligned line that holds it, and merges lanes that share a line. It then issues one transaction per distinct line, lowest line address first, under a valid/ready handshake on the memory side.

Each lane is tagged with the issue index of the transaction that serves it, so that a later return path can steer line data back to lanes. When the last transaction has been accepted, the block pulses a completion flag and presents the number of transactions it issued. That number depends only on how many distinct lines were touched. A contiguous group access that starts off a line boundary therefore costs one transaction more than the same access made aligned.

Top module: `coal_top`

## Requirements
- R1: The line address issued on `mem_line_o` is the lane byte address with its low 7 bits removed (lines are 128 bytes and aligned on 128-byte boundaries).
- R2: Exactly one transaction is accepted per distinct line touched by the active lanes. `txn_count_o` equals that number when `done_o` pulses.
- R3: Transactions are issued in strictly ascending line-address order.
- R4: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o` and `mem_line_o` hold their values in the next cycle.
- R5: Lanes whose active bit is 0 contribute no line and finish with a tag of 0.
- R6: A start with every lane inactive issues no transaction and pulses `done_o` in the cycle after the start, with `txn_count_o` equal to 0.
- R7: `done_o` is high for exactly one cycle, the cycle after the final transaction is accepted. `txn_count_o` holds its value until the next accepted start.
- R8: Each active lane finishes with a tag equal to the 0-based issue index of the transaction carrying its line.
- R9: A start request while `busy_o` is high is ignored. This includes the cycle in which the final transaction is accepted.
- R10: After reset, `busy_o`, `mem_valid_o` and `done_o` are 0 and `txn_count_o` is 0.
- R11: A 32-lane, 4-byte-stride contiguous access costs one transaction when its base is 128-byte aligned and two otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture a new group when idle |
| lane_act_i | input | LANES | Per-lane active bit |
| lane_addr_i | input | LANES*ADDR_W | Per-lane byte address, lane 0 in the low bits |
| busy_o | output | 1 | Group in progress |
| mem_valid_o | output | 1 | Transaction offered |
| mem_ready_i | input | 1 | Memory accepts the offered transaction |
| mem_line_o | output | ADDR_W-7 | Line address of the offered transaction |
| lane_tag_o | output | LANES*TAG_W | Per-lane issue index of the serving transaction |
| done_o | output | 1 | One-cycle completion pulse |
| txn_count_o | output | CNT_W | Transactions issued for the last group |

## Verification
Two things can happen in the same cycle: the memory can accept the final transaction while a new start request arrives. The bench provokes this by raising start with a different, fully active address set exactly in the final accept cycle and in the first busy cycle. It then judges the result: the completed group must report the original lines, count and tags, and `busy_o` must be low in the done cycle instead of a second group beginning. Ready patterns of always-on, alternating and pseudo-random exercise stalls on top of this.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_ISSUE = 1'b1} coal_state_e;
  localparam int unsigned LINE_OFF_W = 7;  // 128-byte lines
endpackage

// File: rtl/coal_line_min.sv
module coal_line_min #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 25
) (
  input  logic [N-1:0]   pend_i,
  input  logic [N*W-1:0] line_i,
  output logic [W-1:0]   min_o,
  output logic [N-1:0]   match_o,
  output logic           any_o
);
  always_comb begin
    min_o = '1;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && (!any_o || line_i[i*W +: W] < min_o)) begin
        min_o = line_i[i*W +: W];
        any_o = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      match_o[i] = pend_i[i] && (line_i[i*W +: W] == min_o);
    end
  end
endmodule

// File: rtl/coal_tag_bank.sv
module coal_tag_bank #(
  parameter int unsigned N     = 32,
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [N-1:0]     wr_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [N*TAG_W-1:0] tags_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [TAG_W-1:0] tag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tag_q <= '0;
      else if (clr_i)   tag_q <= '0;
      else if (wr_i[g]) tag_q <= tag_i;
    end
    assign tags_o[g*TAG_W +: TAG_W] = tag_q;
  end
endmodule

// File: rtl/coal_top.sv
module coal_top
  import coal_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF_W,
  localparam int unsigned TAG_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [LANES-1:0]        lane_act_i,
  input  logic [LANES*ADDR_W-1:0] lane_addr_i,
  output logic                    busy_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [LINE_W-1:0]       mem_line_o,
  output logic [LANES*TAG_W-1:0]  lane_tag_o,
  output logic                    done_o,
  output logic [CNT_W-1:0]        txn_count_o
);
  coal_state_e             state_q;
  logic [LANES-1:0]        pend_q, match;
  logic [LANES*LINE_W-1:0] lines_q, lines_d;
  logic [LINE_W-1:0]       min_line, last_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    any, done_q, have_last_q;
  logic                    start_fire, accept, last_accept;

  for (genvar g = 0; g < LANES; g++) begin : g_ext
    assign lines_d[g*LINE_W +: LINE_W] = lane_addr_i[g*ADDR_W + LINE_OFF_W +: LINE_W];
  end

  coal_line_min #(.N(LANES), .W(LINE_W)) u_min (
    .pend_i (pend_q),
    .line_i (lines_q),
    .min_o  (min_line),
    .match_o(match),
    .any_o  (any)
  );

  assign start_fire  = start_i && (state_q == ST_IDLE);
  assign mem_valid_o = (state_q == ST_ISSUE) && any;
  assign mem_line_o  = min_line;
  assign accept      = mem_valid_o && mem_ready_i;
  assign last_accept = accept && ((pend_q & ~match) == '0);
  assign busy_o      = (state_q == ST_ISSUE);
  assign done_o      = done_q;
  assign txn_count_o = cnt_q;

  coal_tag_bank #(.N(LANES), .TAG_W(TAG_W)) u_tags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_fire),
    .wr_i  (accept ? match : '0),
    .tag_i (cnt_q[TAG_W-1:0]),
    .tags_o(lane_tag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      lines_q     <= '0;
      cnt_q       <= '0;
      done_q      <= 1'b0;
      last_q      <= '0;
      have_last_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_fire) begin
        pend_q      <= lane_act_i;
        lines_q     <= lines_d;
        cnt_q       <= '0;
        have_last_q <= 1'b0;
        if (lane_act_i == '0) done_q  <= 1'b1;
        else                  state_q <= ST_ISSUE;
      end else if (accept) begin
        pend_q      <= pend_q & ~match;
        cnt_q       <= cnt_q + 1'b1;
        last_q      <= min_line;
        have_last_q <= 1'b1;
        if (last_accept) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && have_last_q |-> mem_line_o > last_q) else $error("order"); // R3
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_line_o)) else $error("hold"); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("pulse"); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_count_o <= CNT_W'(LANES)) else $error("count"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_valid_o) else $error("idle"); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done busy"); // R7
endmodule

// File: tb/sim_coal_top.sv
module sim_coal_top;
  localparam int LANES = 32, ADDR_W = 32, LINE_W = 25, TAG_W = 5, CNT_W = 6;

  logic clk = 0, rst_ni = 0, start = 0, ready = 0;
  logic [LANES-1:0] act = '0;
  logic [LANES*ADDR_W-1:0] addr = '0;
  logic busy, mvalid, done;
  logic [LINE_W-1:0] mline;
  logic [LANES*TAG_W-1:0] tags;
  logic [CNT_W-1:0] tcnt;

  int checks = 0, fails = 0;
  logic [31:0] ta [LANES];
  logic [LANES-1:0] tact;
  logic [LINE_W-1:0] exp_l [LANES];
  int exp_n;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  coal_top #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .lane_act_i(act),
    .lane_addr_i(addr), .busy_o(busy), .mem_valid_o(mvalid), .mem_ready_i(ready),
    .mem_line_o(mline), .lane_tag_o(tags), .done_o(done), .txn_count_o(tcnt));

  task automatic chk(input bit ok, input string req, input longint act_v, input longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic model();
    exp_n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (tact[i]) begin
        logic [LINE_W-1:0] l;
        bit seen;
        l = ta[i][31:7];
        seen = 0;
        for (int k = 0; k < exp_n; k++) if (exp_l[k] == l) seen = 1;
        if (!seen) begin
          int p;
          p = exp_n;
          while (p > 0 && exp_l[p-1] > l) begin exp_l[p] = exp_l[p-1]; p--; end
          exp_l[p] = l;
          exp_n++;
        end
      end
    end
  endtask

  function automatic int idx_of(input logic [LINE_W-1:0] l);
    for (int k = 0; k < exp_n; k++) if (exp_l[k] == l) return k;
    return -1;
  endfunction

  // mode: 0 always ready, 1 alternate, 2 pseudo-random; intrude: start during busy
  task automatic run(input int mode, input bit intrude);
    int got = 0, cyc = 0;
    bit fin = 0;
    model();
    @(negedge clk);
    for (int i = 0; i < LANES; i++) addr[i*ADDR_W +: ADDR_W] = ta[i];
    act = tact;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!fin && cyc < 400) begin
      case (mode)
        0: ready = 1;
        1: ready = cyc[0];
        default: begin lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}; ready = lfsr[0]; end
      endcase
      if (intrude && busy && (cyc == 0 || (mvalid && ready && got == exp_n-1))) begin
        start = 1; act = '1; addr = '0;
      end else start = 0;
      if (done) begin
        fin = 1;
        chk(got == exp_n, "R2 lines issued", got, exp_n);
        chk(tcnt == CNT_W'(exp_n), "R2 txn_count", tcnt, exp_n);
        chk(!busy, "R9 no restart at finish", busy, 0);
        for (int i = 0; i < LANES; i++) begin
          int e;
          e = tact[i] ? idx_of(ta[i][31:7]) : 0;
          if (tags[i*TAG_W +: TAG_W] != TAG_W'(e))
            chk(0, tact[i] ? "R8 lane tag" : "R5 inactive tag", tags[i*TAG_W +: TAG_W], e);
        end
        chk(1, "R8 tags", 0, 0);
      end else if (mvalid && ready) begin
        if (got < exp_n) chk(mline == exp_l[got], "R1 R3 line order", mline, exp_l[got]);
        else chk(0, "R2 extra transaction", got, exp_n);
        got++;
      end
      @(negedge clk);
      start = 0;
      cyc++;
    end
    ready = 0;
    chk(fin, "R7 done seen", fin, 1);
    @(negedge clk);
    chk(!done && tcnt == CNT_W'(exp_n), "R7 pulse one cycle, count held", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mvalid && !done && tcnt == 0, "R10 reset state", {busy, mvalid, done}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R11 sweep of base offsets, 4-byte contiguous
    for (int off = 0; off < 256; off += 4) begin
      for (int i = 0; i < LANES; i++) ta[i] = 32'h1000 + off + 4*i;
      tact = '1;
      run(0, 0);
      chk(tcnt == ((off % 128) == 0 ? 1 : 2), "R11 aligned vs misaligned", tcnt, (off % 128) == 0 ? 1 : 2);
    end
    // strides 1..33 words, descending lane order
    for (int s = 1; s <= 33; s++) begin
      for (int i = 0; i < LANES; i++) ta[i] = 32'h8000 + 4*s*(LANES-1-i);
      tact = '1;
      run(s % 3, 0);
    end
    // permutation within two lines
    for (int i = 0; i < LANES; i++) ta[i] = 32'h4000 + ((i*7) % 64) * 4;
    tact = '1;
    run(2, 0);
    // partial activity, random addresses
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < LANES; i++) begin
        lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]};
        ta[i] = {16'h0, lfsr} ^ (i << 9);
        tact[i] = lfsr[3] | lfsr[8];
      end
      run(r % 3, r % 2 == 1);
    end
    // R6 all inactive
    for (int i = 0; i < LANES; i++) ta[i] = 32'hFFFF_FF80;
    tact = '0;
    @(negedge clk);
    act = '0; start = 1;
    @(negedge clk);
    start = 0;
    chk(done && !mvalid && tcnt == 0, "R6 empty group done next cycle", done, 1);
    // R4 stall hold, single lane
    for (int i = 0; i < LANES; i++) ta[i] = 32'h0;
    tact = 32'h1; ta[0] = 32'h0000_0F85;
    @(negedge clk);
    act = tact; addr[31:0] = ta[0]; start = 1; ready = 0;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    chk(mvalid && mline == 25'h1F, "R4 held under stall R1", mline, 25'h1F);
    ready = 1;
    @(negedge clk);
    ready = 0;
    chk(done && tcnt == 1, "R4 accepted after stall", tcnt, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule